// File: doc/BRIEF.md
# Double-Buffered Stream Allocation Table

This block holds the slot map for a multi-stream link that carries up to four virtual channels inside 64-slot frames. Software fills a shadow table through a simple write port. Each of the four entries holds a source index and a slot count. The link hardware never reads the shadow table. It reads an active copy that changes only on a frame boundary, so a frame is never split between two allocations.

A two-bit commit command moves the shadow table into the active table. Code 1 first asks the link to send an allocation change trigger through a request/acknowledge handshake. It then waits a set number of frame starts after the acknowledge before it swaps. Code 2 swaps at the next frame start with no trigger. Code 0 does nothing. Code 3 is treated like code 0. A pending flag shows that a commit is still in flight.

The link presents the index of the slot it is transmitting. The block answers with the owning virtual channel and its source index, taken from the active table. Slot 0 carries the frame header and is never owned. Entries are laid down in index order starting at slot 1. Any count that does not fit in the frame is cut off and raises an overflow flag.

Top module: `stream_alloc_table`

## Requirements
- R1: After reset, pending, trigReq and overflow are 0, and every slot index reports ownerValid = 0.
- R2: Writes to the shadow table (wrEn with wrSel choosing entry 0..3) do not change the owner outputs until a commit has taken effect.
- R3: cmdCode 2 with cmdValid sets pending in the next cycle and never raises trigReq. The swap happens on the first frameStart after the command, and pending reads 0 in the cycle after that frameStart.
- R4: cmdCode 1 with cmdValid raises pending and trigReq in the next cycle. trigReq stays high until trigAck is seen. Frame starts before the acknowledge leave the active table unchanged.
- R5: After trigAck, the swap happens on the TRIG_FRAMES-th frameStart (default 4) that follows the acknowledge cycle. pending stays 1 until then and reads 0 in the cycle after it.
- R6: cmdCode 0 and cmdCode 3 leave pending, trigReq and the active table unchanged.
- R7: A command issued while pending is 1 is ignored. It does not restart or change the commit in flight.
- R8: Slot 0 is never owned. Entry 0 takes the slots starting at slot 1, and each later entry follows the one before it. An entry with count 0 takes no slots. Slots beyond the sum of the counts report ownerValid = 0.
- R9: When the active counts add up to more than 63, overflow is 1 and slots 1..63 are all owned in entry order, with the excess dropped. A sum of exactly 63 gives overflow 0.
- R10: For an owned slot, ownerVc gives the entry number and ownerSrc gives that entry's source index from the active table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Shadow entry write strobe |
| wrSel | input | 2 | Shadow entry number to write |
| wrSrc | input | SRC_W (2) | Source index written to the entry |
| wrCnt | input | 6 | Slot count written to the entry |
| cmdValid | input | 1 | Commit command strobe |
| cmdCode | input | 2 | 0 none, 1 with trigger, 2 without trigger, 3 none |
| frameStart | input | 1 | One-cycle strobe at each frame boundary |
| trigReq | output | 1 | Request to send the allocation change trigger |
| trigAck | input | 1 | Link has sent the trigger |
| pending | output | 1 | A commit is in progress |
| overflow | output | 1 | Active counts exceed the 63 payload slots |
| slotIdx | input | 6 | Slot currently being transmitted |
| ownerValid | output | 1 | slotIdx is allocated |
| ownerVc | output | 2 | Entry owning slotIdx |
| ownerSrc | output | SRC_W (2) | Source index of the owning entry |

## Verification
A corrupted active table or a wrong running sum shows up at the owner outputs as soon as the affected slot index is presented. A full sweep of 64 slots therefore exposes it within one frame's worth of cycles. A control state that swaps early, late or twice shows up as a sweep that matches the wrong table on the frame right after the expected boundary. It can also show up as pending or trigReq holding the wrong level one cycle after a command, an acknowledge or a frame start. The bench sweeps every slot before and after each commit, so that stale, early and misplaced ownership are all observed at the ports.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_TRIG   = 2'd1,
    CMD_NOTRIG = 2'd2
  } cmd_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_HOLD,
    ST_ARM
  } commit_state_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic copy;
  } sat_strobe_t;

endpackage

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int TRIG_FRAMES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [1:0]  cmdCode,
  input  logic        frameStart,
  input  logic        trigAck,
  output logic        trigReq,
  output logic        pending,
  output sat_strobe_t stb
);

  localparam int FC_W = (TRIG_FRAMES > 1) ? $clog2(TRIG_FRAMES) : 1;
  localparam logic [FC_W-1:0] LAST_FRAME = FC_W'(TRIG_FRAMES - 1);

  commit_state_e state;
  logic [FC_W-1:0] frameCnt;
  logic holdDone;

  assign holdDone = (state == ST_HOLD) && frameStart && (frameCnt == LAST_FRAME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      frameCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdValid && cmdCode == CMD_TRIG)        state <= ST_REQ;
          else if (cmdValid && cmdCode == CMD_NOTRIG) state <= ST_ARM;
        end
        ST_REQ: begin
          if (trigAck) begin
            state    <= ST_HOLD;
            frameCnt <= '0;
          end
        end
        ST_HOLD: begin
          if (holdDone)        state    <= ST_IDLE;
          else if (frameStart) frameCnt <= frameCnt + 1'b1;
        end
        ST_ARM: begin
          if (frameStart) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb      = '0;
    stb.copy = holdDone || ((state == ST_ARM) && frameStart);
  end

  assign pending = (state != ST_IDLE);
  assign trigReq = (state == ST_REQ);

  // R4: the trigger request is held until acknowledged
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trigReq && !trigAck |=> trigReq);

  // R3, R5: a swap ends the commit
  assert_swap_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.copy |=> !pending);

  // R7: commands during a commit do not end or restart it
  assert_ignore_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending && cmdValid && !stb.copy |=> pending);

  // R4: no swap while the trigger is still outstanding
  assert_no_swap_in_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trigReq |-> !stb.copy);

endmodule

// File: rtl/sat_data.sv
module sat_data
  import sat_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int SLOTS  = 64,
  parameter int SRC_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  sat_strobe_t               stb,
  input  logic                      wrEn,
  input  logic [$clog2(NUM_VC)-1:0] wrSel,
  input  logic [SRC_W-1:0]          wrSrc,
  input  logic [$clog2(SLOTS)-1:0]  wrCnt,
  input  logic [$clog2(SLOTS)-1:0]  slotIdx,
  output logic                      ownerValid,
  output logic [$clog2(NUM_VC)-1:0] ownerVc,
  output logic [SRC_W-1:0]          ownerSrc,
  output logic                      overflow
);

  localparam int CNT_W = $clog2(SLOTS);
  localparam int VC_W  = $clog2(NUM_VC);
  localparam int SUM_W = CNT_W + VC_W + 1;

  logic [NUM_VC-1:0][SRC_W-1:0] shadowSrc, actSrc;
  logic [NUM_VC-1:0][CNT_W-1:0] shadowCnt, actCnt;
  logic [NUM_VC-1:0][SUM_W-1:0] endPos;
  logic [SUM_W-1:0]             acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadowSrc <= '0;
      shadowCnt <= '0;
      actSrc    <= '0;
      actCnt    <= '0;
    end else begin
      if (wrEn) begin
        shadowSrc[wrSel] <= wrSrc;
        shadowCnt[wrSel] <= wrCnt;
      end
      if (stb.copy) begin
        actSrc <= shadowSrc;
        actCnt <= shadowCnt;
      end
    end
  end

  // exclusive end slot of each entry, packing from slot 1
  always_comb begin
    acc = SUM_W'(1);
    for (int i = 0; i < NUM_VC; i++) begin
      acc       = acc + SUM_W'(actCnt[i]);
      endPos[i] = acc;
    end
  end

  // lowest entry whose end lies beyond the slot owns it
  always_comb begin
    ownerValid = 1'b0;
    ownerVc    = '0;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      if (slotIdx != '0 && SUM_W'(slotIdx) < endPos[i]) begin
        ownerValid = 1'b1;
        ownerVc    = VC_W'(i);
      end
    end
  end

  assign ownerSrc = actSrc[ownerVc];
  assign overflow = endPos[NUM_VC-1] > SUM_W'(SLOTS);

  // R2: active table moves only on a copy strobe
  assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.copy |=> $stable(actSrc) && $stable(actCnt));

  // R8: header slot never owned
  assert_slot0_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slotIdx == '0 |-> !ownerValid);

  // R9: an oversubscribed frame has every payload slot owned
  assert_overflow_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && slotIdx != '0 |-> ownerValid);

endmodule

// File: rtl/stream_alloc_table.sv
module stream_alloc_table
  import sat_pkg::*;
#(
  parameter int NUM_VC      = 4,
  parameter int SLOTS       = 64,
  parameter int SRC_W       = 2,
  parameter int TRIG_FRAMES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wrEn,
  input  logic [$clog2(NUM_VC)-1:0] wrSel,
  input  logic [SRC_W-1:0]          wrSrc,
  input  logic [$clog2(SLOTS)-1:0]  wrCnt,
  input  logic                      cmdValid,
  input  logic [1:0]                cmdCode,
  input  logic                      frameStart,
  output logic                      trigReq,
  input  logic                      trigAck,
  output logic                      pending,
  output logic                      overflow,
  input  logic [$clog2(SLOTS)-1:0]  slotIdx,
  output logic                      ownerValid,
  output logic [$clog2(NUM_VC)-1:0] ownerVc,
  output logic [SRC_W-1:0]          ownerSrc
);

  sat_strobe_t stb;

  sat_ctrl #(.TRIG_FRAMES(TRIG_FRAMES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .frameStart (frameStart),
    .trigAck    (trigAck),
    .trigReq    (trigReq),
    .pending    (pending),
    .stb        (stb)
  );

  sat_data #(.NUM_VC(NUM_VC), .SLOTS(SLOTS), .SRC_W(SRC_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrSrc      (wrSrc),
    .wrCnt      (wrCnt),
    .slotIdx    (slotIdx),
    .ownerValid (ownerValid),
    .ownerVc    (ownerVc),
    .ownerSrc   (ownerSrc),
    .overflow   (overflow)
  );

endmodule

// File: tb/stream_alloc_table_tb.sv
`timescale 1ns/1ps
module stream_alloc_table_tb;

  localparam int TRIG_FRAMES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [1:0] wrSrc = '0;
  logic [5:0] wrCnt = '0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdCode = '0;
  logic frameStart = 1'b0;
  logic trigAck = 1'b0;
  logic [5:0] slotIdx = '0;
  logic trigReq, pending, overflow, ownerValid;
  logic [1:0] ownerVc, ownerSrc;

  int total = 0;
  int bad = 0;

  typedef struct {
    string tag;
    int slot;
    bit v;
    int vc;
    int src;
  } exp_t;
  exp_t sbQ[$];

  int expSrc[4];
  int expCnt[4];
  int shSrc[4];
  int shCnt[4];

  always #4 clk = ~clk;

  stream_alloc_table #(.TRIG_FRAMES(TRIG_FRAMES)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrSrc(wrSrc),
    .wrCnt(wrCnt), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .frameStart(frameStart), .trigReq(trigReq), .trigAck(trigAck),
    .pending(pending), .overflow(overflow), .slotIdx(slotIdx),
    .ownerValid(ownerValid), .ownerVc(ownerVc), .ownerSrc(ownerSrc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares owner outputs against queued expectations
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      exp_t e;
      bit ok;
      e = sbQ.pop_front();
      ok = (ownerValid == e.v) && (!e.v || (ownerVc == e.vc && ownerSrc == e.src));
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL %s slot %0d actual v=%0d vc=%0d src=%0d expected v=%0d vc=%0d src=%0d",
                 e.tag, e.slot, ownerValid, ownerVc, ownerSrc, e.v, e.vc, e.src);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic writeEntry(input int i, input int src, input int cnt);
    wrEn = 1'b1; wrSel = 2'(i); wrSrc = 2'(src); wrCnt = 6'(cnt);
    shSrc[i] = src; shCnt[i] = cnt;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic command(input int code);
    cmdValid = 1'b1; cmdCode = 2'(code);
    tick();
    cmdValid = 1'b0;
  endtask

  task automatic frame();
    frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
  endtask

  task automatic adopt();
    for (int i = 0; i < 4; i++) begin
      expSrc[i] = shSrc[i];
      expCnt[i] = shCnt[i];
    end
  endtask

  // driver: present every slot and queue the expected owner
  task automatic sweep(input string tag);
    int own[64];
    int pos;
    for (int s = 0; s < 64; s++) own[s] = -1;
    pos = 1;
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < expCnt[i]; k++) begin
        if (pos < 64) own[pos] = i;
        pos++;
      end
    end
    for (int s = 0; s < 64; s++) begin
      exp_t e;
      slotIdx = 6'(s);
      e.tag = tag; e.slot = s; e.v = (own[s] >= 0);
      e.vc = (own[s] >= 0) ? own[s] : 0;
      e.src = (own[s] >= 0) ? expSrc[own[s]] : 0;
      sbQ.push_back(e);
      tick();
    end
    tick();
  endtask

  function automatic bit expOverflow();
    return (expCnt[0] + expCnt[1] + expCnt[2] + expCnt[3]) > 63;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      expSrc[i] = 0; expCnt[i] = 0; shSrc[i] = 0; shCnt[i] = 0;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(pending == 0, "R1 pending", pending, 0);
    chk(trigReq == 0, "R1 trigReq", trigReq, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    sweep("R1");

    // R2 shadow writes invisible; R6 no-action codes
    writeEntry(0, 2, 3);
    writeEntry(1, 1, 0);
    writeEntry(2, 3, 5);
    writeEntry(3, 0, 2);
    sweep("R2");
    command(0);
    chk(pending == 0, "R6 code0 pending", pending, 0);
    command(3);
    chk(pending == 0, "R6 code3 pending", pending, 0);
    chk(trigReq == 0, "R6 code3 trigReq", trigReq, 0);
    frame();
    sweep("R6");

    // R3 commit without trigger, R7 command ignored while pending
    command(2);
    chk(pending == 1, "R3 pending set", pending, 1);
    chk(trigReq == 0, "R3 no trigger", trigReq, 0);
    command(1);
    chk(trigReq == 0, "R7 ignored cmd trigReq", trigReq, 0);
    chk(pending == 1, "R7 still pending", pending, 1);
    frame();
    chk(pending == 0, "R3 pending cleared", pending, 0);
    adopt();
    sweep("R8/R10");
    chk(overflow == 0, "R9 no overflow", overflow, 0);

    // R4, R5 commit with trigger
    writeEntry(0, 1, 10);
    writeEntry(1, 0, 20);
    writeEntry(2, 2, 1);
    writeEntry(3, 3, 4);
    command(1);
    chk(pending == 1, "R4 pending set", pending, 1);
    chk(trigReq == 1, "R4 trigReq raised", trigReq, 1);
    frame();
    frame();
    chk(trigReq == 1, "R4 trigReq held", trigReq, 1);
    sweep("R4");
    trigAck = 1'b1;
    tick();
    trigAck = 1'b0;
    chk(trigReq == 0, "R4 trigReq dropped", trigReq, 0);
    for (int f = 0; f < TRIG_FRAMES - 1; f++) frame();
    chk(pending == 1, "R5 pending before last frame", pending, 1);
    sweep("R5");
    frame();
    chk(pending == 0, "R5 pending cleared", pending, 0);
    adopt();
    sweep("R5");

    // R9 overflow
    writeEntry(0, 1, 40);
    writeEntry(1, 2, 30);
    writeEntry(2, 0, 0);
    writeEntry(3, 3, 5);
    command(2);
    frame();
    adopt();
    chk(overflow == expOverflow(), "R9 overflow set", overflow, 1);
    sweep("R9");

    // R9 boundary: exactly 63
    writeEntry(0, 3, 20);
    writeEntry(1, 2, 20);
    writeEntry(2, 1, 20);
    writeEntry(3, 0, 3);
    command(2);
    frame();
    adopt();
    chk(overflow == 0, "R9 sum 63 no overflow", overflow, 0);
    sweep("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule